// File: doc/BRIEF.md
# Multi-Block Transfer Counter Controller

This block keeps count of the blocks in a host data transfer made of several fixed-size blocks. Before a transfer starts, firmware writes the number of blocks minus one into a 5-bit count field. A start strobe opens the transfer. The data path then sends one pulse each time a block ends. The block counts these pulses down. When the pulse for the final block arrives, it closes the transfer and emits a one-cycle completion pulse.

Firmware can add one block to a running transfer. It does this by writing a self-clearing increment bit, which lets a DMA transfer grow as new blocks become ready. A busy status bit covers the single cycle in which the increment is waiting to be applied. A valid status bit says when the count can be read safely. An optional per-block interrupt flag and an active-low interrupt line report every block end that leaves further blocks to go.

Top module: `mblk_xfer_ctrl`

## Requirements
- R1: After reset, the count field reads 0. The status byte reads valid=1 (bit 7) and busy=0 (bit 6). The control byte reads 0. `xfer_active` and `xfer_done` are low and `irq_n` is high.
- R2: A write to address 0 loads `reg_wdata[4:0]` into the count field, and the new value is readable one cycle later. This load wins over a block end and over an applied increment in the same cycle.
- R3: A block-end pulse during an active transfer works as follows. With a nonzero count it decrements the count by one. With a zero count it drops `xfer_active` and raises `xfer_done` for exactly one cycle, both on the next clock.
- R4: A block-end pulse while no transfer is active leaves the count unchanged. A start strobe during an active transfer has no effect.
- R5: A write to address 1 with bit 0 set does three things. On the next clock it sets busy (count byte bit 6) and clears valid (bit 7). One clock later the count rises by one and busy clears. Control bit 0 always reads 0.
- R6: If an increment is applied in the same cycle as a block end during an active transfer, the count is unchanged, busy clears, and the transfer does not end, even at count 0.
- R7: An increment applied at count 31 leaves the count at 31 and sets the sticky overflow bit (control bit 4). Writing 1 to control bit 4 clears it.
- R8: When flag-enable (control bit 1) is set, the interrupt flag (control bit 3) sets on the clock after a block end that sees a nonzero count. A block end at count 0 does not set it. Writing 1 to control bit 3 clears the flag, and a set in the same cycle wins.
- R9: `irq_n` is low exactly when the interrupt flag, flag-enable and interrupt-enable (control bit 2) are all set.
- R10: Pulsing `host_rst` or `fw_rst` for one clock returns all state to its reset value, including the control bits.
- R11: Writing the count field while an increment is pending drops that increment, and busy clears on the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| host_rst | input | 1 | Synchronous reset from the host side |
| fw_rst | input | 1 | Synchronous reset from firmware |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = count/status byte, 1 = control byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| xfer_start | input | 1 | Opens a transfer |
| blk_end | input | 1 | End-of-block pulse from the data path |
| xfer_active | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle pulse when the last block ends |
| irq_n | output | 1 | Interrupt output, active low |

## Verification
The assertions watch several rules on every cycle. They check the one-step decrement, that a block end outside a transfer leaves the count alone, and that the increment-with-block-end merge keeps the count. They also check that busy never lasts past one cycle without a new request, that the count holds at 31 with overflow set, that overflow stays sticky, that the flag sets after a qualifying block end, and that the done pulse lasts one cycle. Some effects only show up in the bench's scenarios against its reference model. These are the read-back byte layout, the priority of a count write over a pending increment, the end of a transfer extended by an increment at count 0, the interrupt-line combinations, and the two synchronous resets.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int CNT_W  = 5;
    localparam int DATA_W = 8;

    // control byte bit positions (address 1)
    localparam int CTL_INC  = 0;
    localparam int CTL_FEN  = 1;
    localparam int CTL_IEN  = 2;
    localparam int CTL_FLAG = 3;
    localparam int CTL_OVF  = 4;

    // count/status byte bit positions (address 0)
    localparam int STS_BUSY  = 6;
    localparam int STS_VALID = 7;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pend;
        logic             active;
        logic             done;
        logic             ovf;
    } cnt_state_t;

    typedef struct packed {
        logic fen;
        logic ien;
        logic flag;
    } irq_state_t;
endpackage

// File: rtl/mbx_counter.sv
module mbx_counter
    import mbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc_req,
    input  logic             ovf_clr,
    input  logic             xfer_start,
    input  logic             blk_end,
    output logic [CNT_W-1:0] cnt,
    output logic             inc_busy,
    output logic             active,
    output logic             done,
    output logic             ovf,
    output logic             blk_tick,
    output logic             cnt_nz
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    cnt_state_t s_d, s_q;
    logic       tick;

    assign tick = s_q.active & blk_end;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (soft_clr) begin
            s_d = '0;
        end else begin
            if (ovf_clr) begin
                s_d.ovf = 1'b0;
            end
            if (load_en) begin
                s_d.cnt = load_val;
            end else if (s_q.pend && tick) begin
                s_d.cnt = s_q.cnt;
            end else if (s_q.pend) begin
                if (s_q.cnt == CNT_MAX) begin
                    s_d.ovf = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end else if (tick) begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else begin
                    s_d.active = 1'b0;
                    s_d.done   = 1'b1;
                end
            end
            s_d.pend = inc_req;
            if (xfer_start && !s_q.active) begin
                s_d.active = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt      = s_q.cnt;
    assign inc_busy = s_q.pend;
    assign active   = s_q.active;
    assign done     = s_q.done;
    assign ovf      = s_q.ovf;
    assign blk_tick = tick;
    assign cnt_nz   = |s_q.cnt;

    p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !s_q.pend && !load_en && !soft_clr && s_q.cnt != '0)
        |=> (s_q.cnt == $past(s_q.cnt) - 1'b1));

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);

    p_idle_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.active && blk_end && !s_q.pend && !load_en && !soft_clr)
        |=> $stable(s_q.cnt));

    p_busy_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pend && !inc_req) |=> !s_q.pend);

    p_merge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pend && tick && !load_en && !soft_clr)
        |=> ($stable(s_q.cnt) && s_q.active));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pend && !tick && !load_en && !soft_clr && s_q.cnt == CNT_MAX)
        |=> (s_q.cnt == CNT_MAX && s_q.ovf));

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ovf && !ovf_clr && !soft_clr) |=> s_q.ovf);
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_clr,
    input  logic ctl_wr,
    input  logic fen_in,
    input  logic ien_in,
    input  logic flag_clr,
    input  logic blk_tick,
    input  logic cnt_nz,
    output logic fen,
    output logic ien,
    output logic flag,
    output logic irq_n
);
    irq_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (soft_clr) begin
            s_d = '0;
        end else begin
            if (ctl_wr) begin
                s_d.fen = fen_in;
                s_d.ien = ien_in;
            end
            if (flag_clr) begin
                s_d.flag = 1'b0;
            end
            if (blk_tick && cnt_nz && s_q.fen) begin
                s_d.flag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fen   = s_q.fen;
    assign ien   = s_q.ien;
    assign flag  = s_q.flag;
    assign irq_n = ~(s_q.flag & s_q.fen & s_q.ien);

    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_tick && cnt_nz && s_q.fen && !soft_clr) |=> s_q.flag);

    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag && !flag_clr && !soft_clr) |=> s_q.flag);

    p_quiet_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.flag |-> irq_n);
endmodule

// File: rtl/mblk_xfer_ctrl.sv
module mblk_xfer_ctrl
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rst,
    input  logic              fw_rst,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              xfer_start,
    input  logic              blk_end,
    output logic              xfer_active,
    output logic              xfer_done,
    output logic              irq_n
);
    logic             soft_clr;
    logic             wr_cnt, wr_ctl;
    logic [CNT_W-1:0] cnt;
    logic             inc_busy, ovf, blk_tick, cnt_nz;
    logic             fen, ien, flag;
    logic             wdata_unused;

    assign soft_clr     = host_rst | fw_rst;
    assign wr_cnt       = reg_wr & (reg_addr == 1'b0);
    assign wr_ctl       = reg_wr & (reg_addr == 1'b1);
    assign wdata_unused = ^reg_wdata[DATA_W-1:CNT_W];

    mbx_counter u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_clr   (soft_clr),
        .load_en    (wr_cnt),
        .load_val   (reg_wdata[CNT_W-1:0]),
        .inc_req    (wr_ctl & reg_wdata[CTL_INC]),
        .ovf_clr    (wr_ctl & reg_wdata[CTL_OVF]),
        .xfer_start (xfer_start),
        .blk_end    (blk_end),
        .cnt        (cnt),
        .inc_busy   (inc_busy),
        .active     (xfer_active),
        .done       (xfer_done),
        .ovf        (ovf),
        .blk_tick   (blk_tick),
        .cnt_nz     (cnt_nz)
    );

    mbx_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .ctl_wr   (wr_ctl),
        .fen_in   (reg_wdata[CTL_FEN]),
        .ien_in   (reg_wdata[CTL_IEN]),
        .flag_clr (wr_ctl & reg_wdata[CTL_FLAG]),
        .blk_tick (blk_tick),
        .cnt_nz   (cnt_nz),
        .fen      (fen),
        .ien      (ien),
        .flag     (flag),
        .irq_n    (irq_n)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == 1'b0) begin
            reg_rdata[CNT_W-1:0] = cnt;
            reg_rdata[STS_BUSY]  = inc_busy;
            reg_rdata[STS_VALID] = ~inc_busy;
        end else begin
            reg_rdata[CTL_FEN]  = fen;
            reg_rdata[CTL_IEN]  = ien;
            reg_rdata[CTL_FLAG] = flag;
            reg_rdata[CTL_OVF]  = ovf;
        end
    end

    p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (!xfer_active && irq_n && !inc_busy));
endmodule

// File: tb/mblk_xfer_ctrl_test.sv
module mblk_xfer_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_rst = 1'b0, fw_rst = 1'b0;
    logic       reg_wr = 1'b0, reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       xfer_start = 1'b0, blk_end = 1'b0;
    logic       xfer_active, xfer_done, irq_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference model state
    int m_cnt = 0;
    bit m_pend = 0, m_act = 0, m_done = 0, m_ovf = 0, m_flag = 0, m_fen = 0, m_ien = 0;

    always #10 clk = ~clk;

    mblk_xfer_ctrl uut (
        .clk(clk), .rst_n(rst_n), .host_rst(host_rst), .fw_rst(fw_rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xfer_start(xfer_start), .blk_end(blk_end),
        .xfer_active(xfer_active), .xfer_done(xfer_done), .irq_n(irq_n)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        int e0, e1;
        e0 = (int'(!m_pend) << 7) | (int'(m_pend) << 6) | m_cnt;
        e1 = (int'(m_ovf) << 4) | (int'(m_flag) << 3) | (int'(m_ien) << 2) | (int'(m_fen) << 1);
        reg_addr = 1'b0; #1;
        chk(tag, "count byte", int'(reg_rdata), e0);
        reg_addr = 1'b1; #1;
        chk(tag, "control byte", int'(reg_rdata), e1);
        chk(tag, "xfer_active", int'(xfer_active), int'(m_act));
        chk(tag, "xfer_done", int'(xfer_done), int'(m_done));
        chk(tag, "irq_n", int'(irq_n), int'(!(m_flag && m_fen && m_ien)));
    endtask

    // drive one cycle at a falling edge, advance the model at the rising edge
    task automatic step(input bit wr, input bit a, input logic [7:0] d,
                        input bit st, input bit be, input bit hr, input bit fr,
                        input string tag);
        bit tick, wr0, wr1;
        int ncnt;
        bit npend, nact, ndone, novf, nflag, nfen, nien;
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        xfer_start = st; blk_end = be; host_rst = hr; fw_rst = fr;
        @(posedge clk);
        tick = m_act && be;
        wr0 = wr && !a;
        wr1 = wr && a;
        ncnt = m_cnt; nact = m_act; ndone = 0; novf = m_ovf;
        nflag = m_flag; nfen = m_fen; nien = m_ien;
        if (hr || fr) begin
            ncnt = 0; npend = 0; nact = 0; novf = 0; nflag = 0; nfen = 0; nien = 0;
        end else begin
            if (wr1 && d[4]) novf = 0;
            if (wr0) ncnt = int'(d[4:0]);
            else if (m_pend && tick) ncnt = m_cnt;
            else if (m_pend) begin
                if (m_cnt == 31) novf = 1; else ncnt = m_cnt + 1;
            end else if (tick) begin
                if (m_cnt != 0) ncnt = m_cnt - 1;
                else begin nact = 0; ndone = 1; end
            end
            npend = wr1 && d[0];
            if (st && !m_act) nact = 1;
            if (wr1) begin nfen = d[1]; nien = d[2]; end
            if (wr1 && d[3]) nflag = 0;
            if (tick && m_cnt != 0 && m_fen) nflag = 1;
        end
        m_cnt = ncnt; m_pend = npend; m_act = nact; m_done = ndone;
        m_ovf = novf; m_flag = nflag; m_fen = nfen; m_ien = nien;
        @(negedge clk);
        reg_wr = 0; reg_wdata = 8'h00; xfer_start = 0; blk_end = 0; host_rst = 0; fw_rst = 0;
        compare_all(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 8'h00, 0, 0, 0, 0, tag);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare_all("R1");                          // R1 reset state
        idle(2, "R1");

        // R2: load and read back
        step(1, 0, 8'h05, 0, 0, 0, 0, "R2");
        idle(1, "R2");
        step(1, 0, 8'hE3, 0, 0, 0, 0, "R2");        // upper bits ignored, count 3

        // R4: block end while idle
        step(0, 0, 8'h00, 0, 1, 0, 0, "R4");

        // R3: run down 3,2,1,0 then end
        step(0, 0, 8'h00, 1, 0, 0, 0, "R3");
        step(0, 0, 8'h00, 1, 0, 0, 0, "R4");        // start while active
        for (int i = 0; i < 4; i++) begin
            step(0, 0, 8'h00, 0, 1, 0, 0, "R3");
            idle(1, "R3");
        end
        idle(2, "R3");

        // R5/R6: extend a running transfer
        step(1, 0, 8'h01, 0, 0, 0, 0, "R2");
        step(0, 0, 8'h00, 1, 0, 0, 0, "R3");
        step(1, 1, 8'h01, 0, 0, 0, 0, "R5");        // increment: busy next
        idle(2, "R5");
        step(1, 1, 8'h01, 0, 0, 0, 0, "R6");
        step(0, 0, 8'h00, 0, 1, 0, 0, "R6");        // merge with block end
        step(0, 0, 8'h00, 0, 1, 0, 0, "R3");
        step(0, 0, 8'h00, 0, 1, 0, 0, "R3");
        step(1, 1, 8'h01, 0, 0, 0, 0, "R6");        // count 0 now
        step(0, 0, 8'h00, 0, 1, 0, 0, "R6");        // merge at zero: transfer stays
        step(0, 0, 8'h00, 0, 1, 0, 0, "R3");        // now ends
        idle(2, "R3");

        // R11: count write over a pending increment
        step(1, 1, 8'h01, 0, 0, 0, 0, "R11");
        step(1, 0, 8'h09, 0, 0, 0, 0, "R11");
        idle(2, "R11");

        // R7: saturation and sticky overflow
        step(1, 0, 8'h1F, 0, 0, 0, 0, "R7");
        step(1, 1, 8'h01, 0, 0, 0, 0, "R7");
        idle(3, "R7");
        step(1, 1, 8'h10, 0, 0, 0, 0, "R7");        // W1C overflow
        idle(1, "R7");

        // R8/R9: per-block flag and interrupt line
        step(1, 0, 8'h02, 0, 0, 0, 0, "R8");
        step(1, 1, 8'h02, 1, 0, 0, 0, "R8");        // flag enable only
        step(0, 0, 8'h00, 0, 1, 0, 0, "R8");
        idle(1, "R9");
        step(1, 1, 8'h06, 0, 0, 0, 0, "R9");        // interrupt enable too
        idle(1, "R9");
        step(1, 1, 8'h0E, 0, 1, 0, 0, "R8");        // clear and set same cycle
        step(1, 1, 8'h0E, 0, 0, 0, 0, "R8");        // W1C
        step(0, 0, 8'h00, 0, 1, 0, 0, "R8");        // count 0: no flag, ends
        idle(2, "R9");
        step(1, 1, 8'h04, 0, 0, 0, 0, "R9");        // flag enable off
        idle(1, "R9");

        // R10: host and firmware resets
        step(1, 0, 8'h07, 0, 0, 0, 0, "R10");
        step(1, 1, 8'h07, 1, 0, 0, 0, "R10");
        step(0, 0, 8'h00, 0, 0, 1, 0, "R10");
        step(1, 0, 8'h04, 0, 0, 0, 0, "R10");
        step(1, 1, 8'h17, 1, 0, 0, 0, "R10");
        step(0, 0, 8'h00, 0, 0, 0, 1, "R10");
        idle(2, "R10");

        finish_run();
    end
endmodule